// File: doc/BRIEF.md
# Dual-Core Wake and Event Line Controller

This block collects a set of external request lines and shares them between two CPUs. Each line is one of two kinds, fixed by a parameter. A configurable line has its own rising-edge and falling-edge trigger enables. A direct line belongs to a peripheral that raises its own interrupt. Inputs are asynchronous. They are brought into the bus clock domain through two flops, and a third flop holds the previous value so that edges can be found.

A trigger on a configurable line can set a pending bit, which is shared by both CPUs. The pending bit drives one interrupt output per line, and both CPUs see that output. Each CPU has its own interrupt mask and event mask. Together these masks decide, for that CPU, whether the pending bit latches, whether a single-cycle event pulse fires and whether a wakeup request is raised. Direct lines never latch and never interrupt. They can only give a wakeup and an event pulse.

A small register port sets the trigger enables and the four masks, and clears pending bits.

Top module: `xevt_dualcore`

## Requirements
- R1: After a synchronous active-low reset, every trigger enable, every mask and every pending bit is 0, and `irq_o`, `evt_o` and `wake_o` are all low.
- R2: A configurable line raises a request only on an edge it is enabled for: a 0→1 change when its rise enable is set, or a 1→0 change when its fall enable is set. If both enables are clear, edges on the line change no output and no register.
- R3: When a request arrives on a configurable line and either CPU has that line's interrupt mask bit at 1, the line's pending bit is set. `irq_o[i]` follows the pending bit.
- R4: For a CPU whose interrupt mask bit is 0 and event mask bit is 1, a request latches nothing for that CPU. That CPU still gets an event pulse and a wakeup.
- R5: For a CPU whose interrupt mask bit and event mask bit are both 0 on every line, no request produces an event pulse or a wakeup for that CPU.
- R6: `evt_o[c]` is high for one cycle, three clock edges after the input change is first sampled. It fires only when at least one request in that cycle is unmasked by CPU c's event mask. It is never high in two consecutive cycles.
- R7: `wake_o[c]` is high for one cycle when a request is unmasked by either of CPU c's masks. It also stays high while any pending bit whose interrupt mask bit for CPU c is 1 remains set.
- R8: Writing 1 to a bit at the pending address clears that bit. Writing 0 leaves it unchanged. If a new request sets the bit in the same cycle as the clear, the bit stays set.
- R9: Direct lines (parameter `DIRECT`, by default bits 7 and 6) never set a pending bit or `irq_o`. They request on a synchronized 0→1 change. Their trigger enable bits read back as 0.
- R10: Register map on `addr_i`: 0 rise enables, 1 fall enables, 2 CPU0 interrupt mask, 3 CPU0 event mask, 4 CPU1 interrupt mask, 5 CPU1 event mask, 6 pending (write 1 to clear). `rdata_o` is combinational from `addr_i`. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_i | input | LINES | Asynchronous request lines |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | LINES | Write data |
| rdata_o | output | LINES | Read data |
| irq_o | output | LINES | Per-line interrupt, shared by both CPUs |
| evt_o | output | 2 | Per-CPU event pulse |
| wake_o | output | 2 | Per-CPU wakeup request |

## Verification
Some properties are checked by assertions on every cycle:
- an event pulse never lasts two cycles;
- an event only follows a cycle in which that CPU's event mask was nonzero;
- a CPU with no mask bits set never wakes;
- pending bits only drop on a clear write;
- pending bits only rise on lines that had a trigger enabled.

Other behaviour only shows up in the bench's scenarios, which a behavioural model checks cycle by cycle. This covers the exact three-edge latency, the separate results of each mask combination per CPU, set winning over a coincident clear, and direct lines that wake without interrupting.

// File: rtl/xevt_dualcore.sv
module xevt_dualcore #(
  parameter int unsigned       LINES  = 8,
  parameter logic [LINES-1:0]  DIRECT = 8'hC0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_i,
  input  logic             wr_en_i,
  input  logic [2:0]       addr_i,
  input  logic [LINES-1:0] wdata_i,
  output logic [LINES-1:0] rdata_o,
  output logic [LINES-1:0] irq_o,
  output logic [1:0]       evt_o,
  output logic [1:0]       wake_o
);
  localparam logic [LINES-1:0] CFG    = ~DIRECT;
  localparam logic [2:0]       A_RISE = 3'd0;
  localparam logic [2:0]       A_FALL = 3'd1;
  localparam logic [2:0]       A_IM0  = 3'd2;
  localparam logic [2:0]       A_EM0  = 3'd3;
  localparam logic [2:0]       A_IM1  = 3'd4;
  localparam logic [2:0]       A_EM1  = 3'd5;
  localparam logic [2:0]       A_PEND = 3'd6;

  logic [LINES-1:0] s1_q, s2_q, prev_q;
  logic [LINES-1:0] rise_q, fall_q, pend_q;
  logic [LINES-1:0] im_q [2];
  logic [LINES-1:0] em_q [2];
  logic [LINES-1:0] up_det, dn_det, req, clr;

  assign up_det = s2_q & ~prev_q;
  assign dn_det = ~s2_q & prev_q;
  assign req    = (CFG & ((rise_q & up_det) | (fall_q & dn_det))) | (DIRECT & up_det);
  assign clr    = (wr_en_i && addr_i == A_PEND) ? wdata_i : '0;
  assign irq_o  = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= line_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      im_q[0] <= '0;
      im_q[1] <= '0;
      em_q[0] <= '0;
      em_q[1] <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_RISE:  rise_q  <= wdata_i & CFG;
        A_FALL:  fall_q  <= wdata_i & CFG;
        A_IM0:   im_q[0] <= wdata_i;
        A_EM0:   em_q[0] <= wdata_i;
        A_IM1:   im_q[1] <= wdata_i;
        A_EM1:   em_q[1] <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | (req & CFG & (im_q[0] | im_q[1]));
  end

  always_comb begin
    case (addr_i)
      A_RISE:  rdata_o = rise_q;
      A_FALL:  rdata_o = fall_q;
      A_IM0:   rdata_o = im_q[0];
      A_EM0:   rdata_o = em_q[0];
      A_IM1:   rdata_o = im_q[1];
      A_EM1:   rdata_o = em_q[1];
      A_PEND:  rdata_o = pend_q;
      default: rdata_o = '0;
    endcase
  end

  for (genvar c = 0; c < 2; c++) begin : g_cpu
    logic ev_any, ev_prev_q, evt_q, wk_q;
    assign ev_any = |(req & em_q[c]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ev_prev_q <= 1'b0;
        evt_q     <= 1'b0;
        wk_q      <= 1'b0;
      end else begin
        ev_prev_q <= ev_any;
        evt_q     <= ev_any & ~ev_prev_q;
        wk_q      <= |(req & (im_q[c] | em_q[c]));
      end
    end

    assign evt_o[c]  = evt_q;
    assign wake_o[c] = wk_q | |(pend_q & im_q[c]);

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o[c] |=> !evt_o[c]); // R6
    AST_EVT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o[c] |-> ($past(em_q[c]) != '0)); // R4
    AST_NO_MASK_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      ((im_q[c] | em_q[c]) == '0 && $past(im_q[c] | em_q[c]) == '0) |-> !wake_o[c]); // R5
  end

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == A_PEND) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R8
  AST_TRIG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~$past(pend_q) & ~$past(rise_q | fall_q)) == '0); // R2
  AST_DIRECT_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & DIRECT) == '0 |=> (irq_o & DIRECT) == '0); // R9
endmodule

// File: tb/test_xevt_dualcore.sv
module test_xevt_dualcore;
  localparam int unsigned LINES = 8;
  localparam logic [7:0] DIR = 8'hC0;
  localparam logic [7:0] CFG = ~DIR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] line_i = '0;
  logic wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, irq_o;
  logic [1:0] evt_o, wake_o;

  int checks = 0;
  int errors = 0;
  int seen_evt [2];
  int seen_wake [2];
  int seen_irq;

  always #10 clk = ~clk;

  xevt_dualcore #(.LINES(LINES), .DIRECT(DIR)) i_xevt_dualcore (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .evt_o(evt_o), .wake_o(wake_o));

  // behavioural reference
  logic [7:0] m_s1, m_s2, m_pv, m_rise, m_fall, m_pend;
  logic [7:0] m_im [2];
  logic [7:0] m_em [2];
  bit m_evp [2];
  bit m_evt [2];
  bit m_wk [2];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_pv = 0; m_rise = 0; m_fall = 0; m_pend = 0;
      for (int c = 0; c < 2; c++) begin
        m_im[c] = 0; m_em[c] = 0; m_evp[c] = 0; m_evt[c] = 0; m_wk[c] = 0;
      end
    end else begin
      logic [7:0] up, dn, rq, cl;
      up = m_s2 & ~m_pv;
      dn = ~m_s2 & m_pv;
      rq = 0;
      for (int i = 0; i < 8; i++) begin
        if (DIR[i]) rq[i] = up[i];
        else rq[i] = (m_rise[i] && up[i]) || (m_fall[i] && dn[i]);
      end
      cl = (wr_en_i && addr_i == 3'd6) ? wdata_i : 8'h00;
      for (int c = 0; c < 2; c++) begin
        bit any;
        any = (rq & m_em[c]) != 0;
        m_evt[c] = any && !m_evp[c];
        m_evp[c] = any;
        m_wk[c] = (rq & (m_im[c] | m_em[c])) != 0;
      end
      m_pend = (m_pend & ~cl) | (rq & CFG & (m_im[0] | m_im[1]));
      m_pv = m_s2; m_s2 = m_s1; m_s1 = line_i;
      if (wr_en_i) begin
        case (addr_i)
          3'd0: m_rise = wdata_i & CFG;
          3'd1: m_fall = wdata_i & CFG;
          3'd2: m_im[0] = wdata_i;
          3'd3: m_em[0] = wdata_i;
          3'd4: m_im[1] = wdata_i;
          3'd5: m_em[1] = wdata_i;
          default: ;
        endcase
      end
    end
    #5;
    chk(irq_o === m_pend, "R3 irq_o", irq_o, m_pend);
    for (int c = 0; c < 2; c++) begin
      bit wexp;
      wexp = m_wk[c] || ((m_pend & m_im[c]) != 0);
      chk(evt_o[c] === m_evt[c], "R6 evt_o", evt_o[c], m_evt[c]);
      chk(wake_o[c] === wexp, "R7 wake_o", wake_o[c], wexp);
      if (evt_o[c]) seen_evt[c]++;
      if (wake_o[c]) seen_wake[c]++;
    end
    if (irq_o != 0) seen_irq++;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_en_i = 0; addr_i = 3'd7; wdata_i = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr_i = a; #2;
    chk(rdata_o === exp, tag, rdata_o, exp);
  endtask

  task automatic line_set(input logic [7:0] v, input int wait_cyc);
    @(negedge clk); line_i = v;
    repeat (wait_cyc) @(negedge clk);
  endtask

  task automatic clr_seen;
    seen_evt[0] = 0; seen_evt[1] = 0; seen_wake[0] = 0; seen_wake[1] = 0; seen_irq = 0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clr_seen();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, "R1 reset register");
    chk({irq_o, evt_o, wake_o} === 12'h0, "R1 outputs", {irq_o, evt_o, wake_o}, 0);

    // R2 no triggers: edges do nothing
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); clr_seen();
    line_set(8'h0F, 6); line_set(8'h00, 6);
    rd(3'd6, 8'h00, "R2 pending without trigger");
    chk(seen_evt[0] == 0 && seen_wake[0] == 0, "R2 no activity", seen_evt[0], 0);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);

    // R10 register readback, R9 direct trigger bits read 0
    wr(3'd0, 8'hFF); rd(3'd0, 8'h3F, "R9 rise on direct reads 0");
    wr(3'd1, 8'hA5); rd(3'd1, 8'h25, "R10 fall readback");
    wr(3'd5, 8'h5A); rd(3'd5, 8'h5A, "R10 em1 readback");
    rd(3'd7, 8'h00, "R10 unused address");
    wr(3'd1, 8'h00); wr(3'd5, 8'h00); wr(3'd0, 8'h01);

    // R3 rising edge with CPU0 interrupt mask
    wr(3'd2, 8'h01); clr_seen();
    line_set(8'h01, 6);
    rd(3'd6, 8'h01, "R3 pending set");
    chk(irq_o === 8'h01, "R3 irq", irq_o, 1);
    chk(wake_o === 2'b01, "R7 wake held", wake_o, 1);
    chk(seen_evt[0] == 0, "R5 no event w/o em", seen_evt[0], 0);
    chk(seen_wake[1] == 0, "R5 cpu1 silent", seen_wake[1], 0);
    // R8 write 0 no effect, write 1 clears
    wr(3'd6, 8'h00); rd(3'd6, 8'h01, "R8 write zero kept");
    wr(3'd6, 8'h01); rd(3'd6, 8'h00, "R8 write one cleared");
    chk(wake_o === 2'b00, "R7 wake released", wake_o, 0);
    line_set(8'h00, 4);

    // R4 CPU1 event only, falling edge on line 1
    wr(3'd2, 8'h00); wr(3'd1, 8'h02); wr(3'd5, 8'h02);
    line_set(8'h02, 6); clr_seen();
    line_set(8'h00, 6);
    chk(seen_evt[1] == 1, "R6 one event pulse", seen_evt[1], 1);
    chk(seen_wake[1] == 1, "R4 wake pulse", seen_wake[1], 1);
    rd(3'd6, 8'h00, "R4 nothing latched");
    chk(seen_evt[0] == 0 && seen_wake[0] == 0, "R5 cpu0 silent", seen_evt[0], 0);

    // R9 direct line 7 with CPU0 event mask and interrupt mask
    wr(3'd3, 8'h80); wr(3'd2, 8'h80); clr_seen();
    line_set(8'h80, 6);
    chk(seen_evt[0] == 1 && seen_irq == 0, "R9 direct event no irq", seen_irq, 0);
    rd(3'd6, 8'h00, "R9 direct no pending");
    line_set(8'h00, 4);

    // random phase: includes clear coinciding with set (R8)
    wr(3'd0, 8'h33); wr(3'd1, 8'h5C); wr(3'd2, 8'h0F); wr(3'd3, 8'hC3);
    wr(3'd4, 8'hF0); wr(3'd5, 8'h99);
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      line_i = 8'($urandom);
      wr_en_i = ($urandom % 4) == 0;
      addr_i = ($urandom % 3 != 0) ? 3'd6 : 3'($urandom % 8);
      wdata_i = 8'($urandom);
    end
    @(negedge clk); wr_en_i = 0;
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule